// File: doc/BRIEF.md
# Strap-Aware GPIO Port with Status Outputs

This block is a 16-pin general-purpose I/O port driven through a small register interface. Software selects each pin's direction, writes the values that output pins drive, and reads back pin state through a separate input register. Inputs from the pads are asynchronous to the core clock, so each one passes through a two-flop synchronizer before software can see it.

Pins 0, 1 and 2 behave differently from the rest. When set as outputs, they carry internal status signals instead of register data. Pin 0 shows any uncorrectable memory error, from either a datapath memory or a non-data memory. Pin 1 shows that the host link is out of its data-link-active state. Pin 2 shows that an interrupt is pending. Pins 3 to 15 drive the software-written values.

While reset is asserted, and for a fixed strap window after it, every pin stays tri-stated so that board straps on the pins can be sampled. The core reset is asserted asynchronously and released in step with the clock.

Top module: `gpio_status_port`

## Requirements
- R1: While `rst_n` is low, `pad_oe` is all zeros, and the direction and output-data registers read as zero.
- R2: After reset is released, all `pad_oe` bits stay low for `STRAP_CYCLES` cycles. Direction writes made during that window are dropped, so the direction register still reads zero once the window ends.
- R3: After the strap window, a direction write takes effect at the next rising clock edge. From then on, `pad_oe[i]` equals direction bit i, where 1 means output.
- R4: `pad_out[0]` is the OR of `ecc_dpath_err` and `ecc_ctrl_err`.
- R5: `pad_out[1]` is high exactly when `link_up` is low.
- R6: `pad_out[2]` follows `irq_pending`.
- R7: `pad_out[15:3]` equals bits 15:3 of the output-data register. Bits 2:0 of that register have no effect on any pin.
- R8: For an input pin, the input register shows a change on `pad_in` after exactly two rising edges and not after one.
- R9: For an output pin, the input register returns the value the pin drives, whatever `pad_in` carries.
- R10: The register map is as follows. Address 0 is direction, address 1 is output data, and address 2 is input, which is read-only. Address 3 reads as zero. Writes to address 2 or 3 change neither the direction nor the output-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from `reg_addr`) |
| ecc_dpath_err | input | 1 | Uncorrectable error flag from datapath memories |
| ecc_ctrl_err | input | 1 | Uncorrectable error flag from non-data memories |
| link_up | input | 1 | Host link is in its data-link-active state |
| irq_pending | input | 1 | Some interrupt is pending |
| pad_in | input | 16 | Asynchronous pad input values |
| pad_out | output | 16 | Values offered to the pad drivers |
| pad_oe | output | 16 | Pad output enables, 1 means driving |

## Verification
A strap counter that ends early or late shows at once as `pad_oe` going high before the window closes, or as a direction write that is lost after it. A synchronizer with the wrong depth shows in the input register one cycle early or one cycle late, so both the one-edge and the two-edge points are sampled. A swapped status source or a wrong mux boundary shows on `pad_out[2:0]` in the same cycle the status input changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned STATUS_PINS = 3;
  localparam int unsigned ADDR_W      = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_IN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_strap_timer.sv
module gpio_strap_timer #(
  parameter int unsigned STRAP_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  output logic strap_active
);
  localparam int unsigned CNT_W = $clog2(STRAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STRAP_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign strap_active = (cnt_q != CNT_END);
  assign cnt_en       = strap_active;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        meta_q <= d_async[i];
        hold_q <= meta_q;
      end
    end
    assign q_sync[i] = hold_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_active,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PIN_COUNT-1:0] wdata,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] dout_q
);
  logic                 dir_we;
  logic                 dout_we;
  logic [PIN_COUNT-1:0] dir_d;
  logic [PIN_COUNT-1:0] dout_d;

  always_comb begin
    dir_we  = wr_en && (addr == SEL_DIR) && !strap_active;
    dout_we = wr_en && (addr == SEL_OUT);
    dir_d   = wdata;
    dout_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_we) dout_q <= dout_d;
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16
) (
  input  logic [STATUS_PINS-1:0] status_vec,
  input  logic [PIN_COUNT-1:0]   dir_q,
  input  logic [PIN_COUNT-1:0]   dout_q,
  input  logic                   strap_active,
  input  logic [PIN_COUNT-1:0]   sync_in,
  output logic [PIN_COUNT-1:0]   pad_out,
  output logic [PIN_COUNT-1:0]   pad_oe,
  output logic [PIN_COUNT-1:0]   pin_view
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    if (i < STATUS_PINS) begin : g_status
      assign pad_out[i] = status_vec[i];
    end else begin : g_soft
      assign pad_out[i] = dout_q[i];
    end
    assign pad_oe[i]   = dir_q[i] & ~strap_active;
    assign pin_view[i] = pad_oe[i] ? pad_out[i] : sync_in[i];
  end
endmodule

// File: rtl/gpio_status_port.sv
module gpio_status_port
  import gpio_pkg::*;
#(
  parameter int unsigned PIN_COUNT    = 16,
  parameter int unsigned STRAP_CYCLES = 4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [PIN_COUNT-1:0] reg_wdata,
  output logic [PIN_COUNT-1:0] reg_rdata,
  input  logic                 ecc_dpath_err,
  input  logic                 ecc_ctrl_err,
  input  logic                 link_up,
  input  logic                 irq_pending,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);
  logic                   rst_n_sync;
  logic                   strap_active;
  logic [PIN_COUNT-1:0]   dir_q;
  logic [PIN_COUNT-1:0]   dout_q;
  logic [PIN_COUNT-1:0]   sync_q;
  logic [PIN_COUNT-1:0]   pin_view;
  logic [STATUS_PINS-1:0] status_vec;

  assign status_vec = {irq_pending, ~link_up, ecc_dpath_err | ecc_ctrl_err};

  gpio_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_strap_timer #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .strap_active (strap_active)
  );

  gpio_in_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .d_async (pad_in),
    .q_sync  (sync_q)
  );

  gpio_regs #(.PIN_COUNT(PIN_COUNT)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .strap_active (strap_active),
    .wr_en        (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .dir_q        (dir_q),
    .dout_q       (dout_q)
  );

  gpio_pin_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
    .status_vec   (status_vec),
    .dir_q        (dir_q),
    .dout_q       (dout_q),
    .strap_active (strap_active),
    .sync_in      (sync_q),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pin_view     (pin_view)
  );

  always_comb begin
    unique case (reg_addr)
      SEL_DIR: reg_rdata = dir_q;
      SEL_OUT: reg_rdata = dout_q;
      SEL_IN:  reg_rdata = pin_view;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_status_port_chk.sv
module gpio_status_port_chk #(
  parameter int unsigned PIN_COUNT = 16
) (
  input logic                 clk,
  input logic                 rst_n_sync,
  input logic                 strap_active,
  input logic [PIN_COUNT-1:0] dir_q,
  input logic [PIN_COUNT-1:0] sync_q,
  input logic [PIN_COUNT-1:0] pad_in,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe,
  input logic                 ecc_dpath_err,
  input logic                 ecc_ctrl_err,
  input logic                 link_up,
  input logic                 irq_pending
);
  logic [1:0] since_q;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)           since_q <= 2'd0;
    else if (since_q != 2'd2)  since_q <= since_q + 2'd1;
  end

  // R2
  strap_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    strap_active |-> (pad_oe == '0));

  // R2
  strap_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    strap_active |=> (dir_q == '0));

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !strap_active |-> (pad_oe == dir_q));

  // R4
  ecc_pin_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pad_out[0] == (ecc_dpath_err | ecc_ctrl_err));

  // R5
  link_pin_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pad_out[1] == !link_up);

  // R6
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    pad_out[2] == irq_pending);

  // R8
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (since_q == 2'd2) |-> (sync_q == $past(pad_in, 2)));
endmodule

bind gpio_status_port gpio_status_port_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
  .clk           (clk),
  .rst_n_sync    (rst_n_sync),
  .strap_active  (strap_active),
  .dir_q         (dir_q),
  .sync_q        (sync_q),
  .pad_in        (pad_in),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .ecc_dpath_err (ecc_dpath_err),
  .ecc_ctrl_err  (ecc_ctrl_err),
  .link_up       (link_up),
  .irq_pending   (irq_pending)
);

// File: tb/sim_gpio_status_port.sv
module sim_gpio_status_port;
  localparam int CLK_PERIOD = 10;
  localparam int PINS       = 16;
  localparam int STRAP      = 120;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_wr;
  logic [1:0]      reg_addr;
  logic [PINS-1:0] reg_wdata;
  logic [PINS-1:0] reg_rdata;
  logic            ecc_dpath_err, ecc_ctrl_err, link_up, irq_pending;
  logic [PINS-1:0] pad_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_status_port #(.PIN_COUNT(PINS), .STRAP_CYCLES(STRAP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ecc_dpath_err(ecc_dpath_err), .ecc_ctrl_err(ecc_ctrl_err),
    .link_up(link_up), .irq_pending(irq_pending),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [PINS-1:0] got, input logic [PINS-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [PINS-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [PINS-1:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    ecc_dpath_err = 1'b0; ecc_ctrl_err = 1'b0; link_up = 1'b1; irq_pending = 1'b0;
    pad_in = 16'h00F0;
    wait_clks(4);
    check("R1 oe in reset", pad_oe, '0);
    reg_read(2'd0, v); check("R1 dir in reset", v, '0);
    reg_read(2'd1, v); check("R1 dout in reset", v, '0);
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic t_strap_window;
    logic [PINS-1:0] v;
    reg_write(2'd0, 16'hFFFF);
    check("R2 oe after early dir write", pad_oe, '0);
    wait_clks(STRAP/2);
    check("R2 oe mid window", pad_oe, '0);
    wait_clks(STRAP);
    reg_read(2'd0, v); check("R2 early dir write dropped", v, '0);
    check("R2 oe after window", pad_oe, '0);
    reg_write(2'd0, 16'hF0F5);
    check("R3 oe follows dir", pad_oe, 16'hF0F5);
    reg_read(2'd0, v); check("R3 dir readback", v, 16'hF0F5);
  endtask

  task automatic t_status_pins;
    reg_write(2'd0, 16'hFFFF);
    ecc_dpath_err = 1'b0; ecc_ctrl_err = 1'b0; #1;
    check("R4 no ecc", {15'd0, pad_out[0]}, 16'd0);
    ecc_dpath_err = 1'b1; #1;
    check("R4 datapath ecc", {15'd0, pad_out[0]}, 16'd1);
    ecc_dpath_err = 1'b0; ecc_ctrl_err = 1'b1; #1;
    check("R4 ctrl ecc", {15'd0, pad_out[0]}, 16'd1);
    ecc_ctrl_err = 1'b0;
    link_up = 1'b1; #1;
    check("R5 link up", {15'd0, pad_out[1]}, 16'd0);
    link_up = 1'b0; #1;
    check("R5 link down", {15'd0, pad_out[1]}, 16'd1);
    link_up = 1'b1;
    irq_pending = 1'b1; #1;
    check("R6 irq set", {15'd0, pad_out[2]}, 16'd1);
    irq_pending = 1'b0; #1;
    check("R6 irq clear", {15'd0, pad_out[2]}, 16'd0);
  endtask

  task automatic t_out_data;
    reg_write(2'd1, 16'hA5A7);
    check("R7 pattern A", pad_out, 16'hA5A0);
    reg_write(2'd1, 16'h5A5F);
    check("R7 pattern B", pad_out, 16'h5A58);
  endtask

  task automatic t_input_sync;
    logic [PINS-1:0] v;
    reg_write(2'd0, 16'h0000);
    pad_in = 16'h0000;
    wait_clks(3);
    @(negedge clk); pad_in = 16'h1234;
    wait_clks(1);
    reg_read(2'd2, v); check("R8 after one edge", v, 16'h0000);
    wait_clks(1);
    reg_read(2'd2, v); check("R8 after two edges", v, 16'h1234);
  endtask

  task automatic t_readback;
    logic [PINS-1:0] v;
    reg_write(2'd1, 16'hAB00);
    reg_write(2'd0, 16'hFF00);
    pad_in = 16'h55CD;
    wait_clks(3);
    reg_read(2'd2, v); check("R9 mixed readback", v, 16'hABCD);
  endtask

  task automatic t_regmap;
    logic [PINS-1:0] v;
    reg_write(2'd2, 16'h0F0F);
    reg_write(2'd3, 16'h3333);
    reg_read(2'd0, v); check("R10 dir unchanged", v, 16'hFF00);
    reg_read(2'd1, v); check("R10 dout unchanged", v, 16'hAB00);
    reg_read(2'd3, v); check("R10 addr 3 reads zero", v, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_strap_window();
    t_status_pins();
    t_out_data();
    t_input_sync();
    t_readback();
    t_regmap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule